// File: doc/BRIEF.md
# E1 Transmit Frame Timing Generator

This block keeps the transmit position on an E1 structure: bit within timeslot (1 to 8), timeslot within frame (0 to 31) and frame within a 16-frame multiframe. It runs on the 2.048 MHz bit clock. From that position it drives a channel clock at timeslot rate, a flag for the signalling timeslot, a flag for frames that carry the alignment pattern, and a flag for multiframe frame 0. It also drives one-cycle strobes that tell the insertion logic downstream which serial input to capture at each bit: international bit, national bits, signalling data and extra data.

Two sync inputs let an upstream source realign the counters. The first marks frame boundaries and the second marks multiframe boundaries. Either input may be held low, and the counters then run free. Edges are detected synchronously. The counters move to the new position on the clock edge that sees the input rise, so the bit after the edge is bit 1 of timeslot 0.

Top module: `e1_tx_timing`

## Requirements
- R1: While reset is asserted, the position is bit 1 of timeslot 0 of frame 0. The outputs then read chclk_o=1, sig_ts_o=0, align_frame_o=1, mf_o=1 and intl_stb_o=1.
- R2: With no sync edge, each clock advances the bit from 1 to 8. After bit 8 the timeslot advances from 0 to 31, and after timeslot 31 the frame advances from 0 to 15. Each counter wraps to its first value.
- R3: chclk_o is high during bits 1 to 4 of every timeslot and low during bits 5 to 8.
- R4: sig_ts_o is high for all eight bits of timeslot 16 in every frame and low at every other position.
- R5: mf_o is high only in frame 0. align_frame_o is high in even-numbered frames and low in odd-numbered frames.
- R6: A rise of fsync_i (high now, low on the previous clock) makes the next position bit 1 of timeslot 0 of the following frame, with the frame number wrapping from 15 to 0. Holding fsync_i high has no further effect.
- R7: A rise of msync_i makes the next position bit 1 of timeslot 0 of frame 0. When fsync_i rises on the same clock, msync_i wins.
- R8: A sync rise that lands on the clock where the counters would reach the same boundary anyway leaves the position sequence unchanged.
- R9: intl_stb_o is high at bit 1 of timeslot 0 in every frame.
- R10: nat_stb_o is high at bits 4 to 8 of timeslot 0 in odd-numbered frames, but only while nat_en_i is 1.
- R11: xd_stb_o is high at bits 5, 7 and 8 of timeslot 16 in frame 0, but only while cas_en_i is 1.
- R12: sig_stb_o is high at every bit of timeslot 16 in frames 1 to 15, but only while cas_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2.048 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; a rising edge realigns to a frame boundary |
| msync_i | input | 1 | Multiframe sync; a rising edge realigns to frame 0 |
| cas_en_i | input | 1 | Enables the signalling and extra-data strobes |
| nat_en_i | input | 1 | Enables the national-bit strobe |
| chclk_o | output | 1 | Channel clock, one period per timeslot |
| sig_ts_o | output | 1 | High during the signalling timeslot |
| align_frame_o | output | 1 | High during alignment frames |
| mf_o | output | 1 | High during multiframe frame 0 |
| xd_stb_o | output | 1 | Extra-data sample strobe |
| sig_stb_o | output | 1 | Signalling-data sample strobe |
| intl_stb_o | output | 1 | International-bit sample strobe |
| nat_stb_o | output | 1 | National-bit sample strobe |

## Verification
Two kinds of collision are provoked.

The first is a frame-sync rise and a multiframe-sync rise on the same clock. The bench must find that the multiframe load wins, so the next position is frame 0 and not the following frame.

The second is a sync rise on the clock where the counters would wrap to the same boundary anyway. The bench waits for bit 8 of timeslot 31, and for frame 15 in the multiframe case, before it raises the sync input. It then requires that the sequence is the same as in free running.

A behavioural position model is compared on every clock and judges both cases.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;
  localparam int unsigned BITS_PER_TS_D   = 8;
  localparam int unsigned TS_PER_FRAME_D  = 32;
  localparam int unsigned FRAMES_PER_MF_D = 16;
  localparam int unsigned SIG_TS_D        = 16;

  typedef struct packed {
    logic intl;
    logic nat;
    logic xd;
    logic sig;
  } strobes_t;
endpackage

// File: rtl/e1_edge_det.sv
module e1_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];

    // R6
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/e1_pos_cnt.sv
module e1_pos_cnt #(
  parameter int unsigned BITS = 8,
  parameter int unsigned TS   = 32,
  parameter int unsigned FR   = 16,
  localparam int unsigned BW  = $clog2(BITS),
  localparam int unsigned TW  = $clog2(TS),
  localparam int unsigned FW  = $clog2(FR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fload_i,
  input  logic          mload_i,
  output logic [BW-1:0] bit_o,
  output logic [TW-1:0] ts_o,
  output logic [FW-1:0] fr_o
);
  logic [BW-1:0] bit_q;
  logic [TW-1:0] ts_q;
  logic [FW-1:0] fr_q, fr_nxt;

  assign fr_nxt = (fr_q == FW'(FR - 1)) ? '0 : fr_q + FW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      ts_q  <= '0;
      fr_q  <= '0;
    end else if (mload_i) begin
      bit_q <= '0;
      ts_q  <= '0;
      fr_q  <= '0;
    end else if (fload_i) begin
      bit_q <= '0;
      ts_q  <= '0;
      fr_q  <= fr_nxt;
    end else if (bit_q == BW'(BITS - 1)) begin
      bit_q <= '0;
      if (ts_q == TW'(TS - 1)) begin
        ts_q <= '0;
        fr_q <= fr_nxt;
      end else begin
        ts_q <= ts_q + TW'(1);
      end
    end else begin
      bit_q <= bit_q + BW'(1);
    end
  end

  assign bit_o = bit_q;
  assign ts_o  = ts_q;
  assign fr_o  = fr_q;

  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fload_i && !mload_i) |=>
      (bit_q == (($past(bit_q) == BW'(BITS - 1)) ? '0 : $past(bit_q) + BW'(1))));
  // R7
  mload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mload_i |=> (bit_q == '0 && ts_q == '0 && fr_q == '0));
  // R6
  fload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fload_i && !mload_i) |=> (bit_q == '0 && ts_q == '0 &&
      fr_q == (($past(fr_q) == FW'(FR - 1)) ? '0 : $past(fr_q) + FW'(1))));
endmodule

// File: rtl/e1_field_dec.sv
module e1_field_dec
  import e1_tx_pkg::*;
#(
  parameter int unsigned BITS   = 8,
  parameter int unsigned TS     = 32,
  parameter int unsigned FR     = 16,
  parameter int unsigned SIG_TS = 16,
  localparam int unsigned BW    = $clog2(BITS),
  localparam int unsigned TW    = $clog2(TS),
  localparam int unsigned FW    = $clog2(FR)
) (
  input  logic [BW-1:0] bit_i,
  input  logic [TW-1:0] ts_i,
  input  logic [FW-1:0] fr_i,
  input  logic          cas_en_i,
  input  logic          nat_en_i,
  output logic          chclk_o,
  output logic          sig_ts_o,
  output logic          align_o,
  output logic          mf_o,
  output strobes_t      stb_o
);
  // zero-based bit indices: bit 4 -> 3, bits 5/7/8 -> 4/6/7
  localparam logic [BW-1:0] NAT_FIRST = BW'(3);
  localparam logic [BW-1:0] XD_A      = BW'(4);
  localparam logic [BW-1:0] XD_B      = BW'(6);
  localparam logic [BW-1:0] XD_C      = BW'(7);

  logic ts0, ts_sig, fr0;

  always_comb begin
    ts0      = (ts_i == '0);
    ts_sig   = (ts_i == TW'(SIG_TS));
    fr0      = (fr_i == '0);
    chclk_o  = (bit_i < BW'(BITS / 2));
    sig_ts_o = ts_sig;
    align_o  = ~fr_i[0];
    mf_o     = fr0;
    stb_o.intl = ts0 && (bit_i == '0);
    stb_o.nat  = nat_en_i && ts0 && fr_i[0] && (bit_i >= NAT_FIRST);
    stb_o.xd   = cas_en_i && ts_sig && fr0 &&
                 (bit_i == XD_A || bit_i == XD_B || bit_i == XD_C);
    stb_o.sig  = cas_en_i && ts_sig && !fr0;
  end
endmodule

// File: rtl/e1_tx_timing.sv
module e1_tx_timing
  import e1_tx_pkg::*;
#(
  parameter int unsigned BITS   = BITS_PER_TS_D,
  parameter int unsigned TS     = TS_PER_FRAME_D,
  parameter int unsigned FR     = FRAMES_PER_MF_D,
  parameter int unsigned SIG_TS = SIG_TS_D,
  localparam int unsigned BW    = $clog2(BITS),
  localparam int unsigned TW    = $clog2(TS),
  localparam int unsigned FW    = $clog2(FR)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic msync_i,
  input  logic cas_en_i,
  input  logic nat_en_i,
  output logic chclk_o,
  output logic sig_ts_o,
  output logic align_frame_o,
  output logic mf_o,
  output logic xd_stb_o,
  output logic sig_stb_o,
  output logic intl_stb_o,
  output logic nat_stb_o
);
  logic [1:0]    rise;
  logic [BW-1:0] bit_pos;
  logic [TW-1:0] ts_pos;
  logic [FW-1:0] fr_pos;
  strobes_t      stb;

  e1_edge_det #(.N(2)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({msync_i, fsync_i}),
    .rise_o (rise)
  );

  e1_pos_cnt #(.BITS(BITS), .TS(TS), .FR(FR)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fload_i (rise[0]),
    .mload_i (rise[1]),
    .bit_o   (bit_pos),
    .ts_o    (ts_pos),
    .fr_o    (fr_pos)
  );

  e1_field_dec #(.BITS(BITS), .TS(TS), .FR(FR), .SIG_TS(SIG_TS)) i_dec (
    .bit_i    (bit_pos),
    .ts_i     (ts_pos),
    .fr_i     (fr_pos),
    .cas_en_i (cas_en_i),
    .nat_en_i (nat_en_i),
    .chclk_o  (chclk_o),
    .sig_ts_o (sig_ts_o),
    .align_o  (align_frame_o),
    .mf_o     (mf_o),
    .stb_o    (stb)
  );

  assign xd_stb_o   = stb.xd;
  assign sig_stb_o  = stb.sig;
  assign intl_stb_o = stb.intl;
  assign nat_stb_o  = stb.nat;

  // R11 R12
  xd_sig_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xd_stb_o && sig_stb_o));
  // R5
  mf_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_o |-> align_frame_o);
  // R9
  intl_outside_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intl_stb_o |-> (!sig_ts_o && chclk_o));
  // R3
  sig_entry_chclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_ts_o) |-> chclk_o);
  // R7
  msync_to_mf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msync_i && !$past(msync_i)) |=> (mf_o && intl_stb_o));
endmodule

// File: tb/test_e1_tx_timing.sv
module test_e1_tx_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, msync = 1'b0, cas_en = 1'b1, nat_en = 1'b1;
  logic chclk, sig_ts, align, mf, xd, sig, intl, nat;

  always #2 clk = ~clk;

  e1_tx_timing i_e1_tx_timing (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .msync_i(msync),
    .cas_en_i(cas_en), .nat_en_i(nat_en), .chclk_o(chclk), .sig_ts_o(sig_ts),
    .align_frame_o(align), .mf_o(mf), .xd_stb_o(xd), .sig_stb_o(sig),
    .intl_stb_o(intl), .nat_stb_o(nat)
  );

  integer checks = 0, fails = 0;
  integer b = 0, t = 0, f = 0;
  logic fsp = 1'b0, msp = 1'b0;
  string phase = "R2";
  bit done = 1'b0;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s b=%0d t=%0d f=%0d actual=%b expected=%b",
               tag, phase, b + 1, t, f, act, exp);
    end
  endtask

  // reference model: position advances, then outputs compared 1 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      b = 0; t = 0; f = 0; fsp = 1'b0; msp = 1'b0;
    end else begin
      if (msync && !msp) begin
        b = 0; t = 0; f = 0;
      end else if (fsync && !fsp) begin
        b = 0; t = 0; f = (f + 1) % 16;
      end else begin
        b = b + 1;
        if (b == 8) begin
          b = 0; t = t + 1;
          if (t == 32) begin t = 0; f = (f + 1) % 16; end
        end
      end
      fsp = fsync; msp = msync;
      #1;
      chk(chclk, b < 4, "R3 chclk");
      chk(sig_ts, t == 16, "R4 sig_ts");
      chk(mf, f == 0, "R5 mf");
      chk(align, (f % 2) == 0, "R5 align");
      chk(intl, t == 0 && b == 0, "R9 intl");
      chk(nat, nat_en && t == 0 && (f % 2) == 1 && b >= 3, "R10 nat");
      chk(xd, cas_en && t == 16 && f == 0 && (b == 4 || b == 6 || b == 7), "R11 xd");
      chk(sig, cas_en && t == 16 && f != 0, "R12 sig");
    end
  end

  task automatic run(input integer n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: state while reset is held
    #3;
    chk(chclk, 1'b1, "R1 chclk");
    chk(sig_ts, 1'b0, "R1 sig_ts");
    chk(align, 1'b1, "R1 align");
    chk(mf, 1'b1, "R1 mf");
    chk(intl, 1'b1, "R1 intl");
    @(negedge clk); rst_n = 1'b1;

    phase = "R2";
    run(16 * 256 + 40);

    // R6: mid-frame frame sync, held high, then released
    phase = "R6";
    run(77);
    fsync = 1'b1;
    @(posedge clk); #1.5;
    chk(intl, 1'b1, "R6 realign");
    run(300);
    fsync = 1'b0;
    run(513);
    fsync = 1'b1; run(1); fsync = 1'b0;
    run(1200);

    // R7: multiframe sync alone, then together with frame sync
    phase = "R7";
    msync = 1'b1;
    @(posedge clk); #1.5;
    chk(mf, 1'b1, "R7 mf");
    chk(intl, 1'b1, "R7 intl");
    run(2);
    msync = 1'b0;
    run(1500);
    fsync = 1'b1; msync = 1'b1;
    @(posedge clk); #1.5;
    chk(mf, 1'b1, "R7 priority");
    run(2);
    fsync = 1'b0; msync = 1'b0;
    run(600);

    // R8: sync rises on natural boundaries
    phase = "R8";
    do @(negedge clk); while (!(b == 7 && t == 31));
    fsync = 1'b1; run(1); fsync = 1'b0;
    do @(negedge clk); while (!(b == 7 && t == 31 && f == 15));
    msync = 1'b1; run(1); msync = 1'b0;
    run(700);

    // R10 R11 R12: enables off, then on again
    phase = "R11";
    cas_en = 1'b0; nat_en = 1'b0;
    run(16 * 256 + 10);
    cas_en = 1'b1; nat_en = 1'b1;
    run(16 * 256 + 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule